// File: doc/BRIEF.md
# Maskable Time-of-Day Alarm Comparator

This block holds a four-field alarm setting (seconds, minutes, hours, date) and compares it with the running BCD time presented on its inputs. The comparison runs only in a cycle where the one-second tick input is high. Each alarm field has its own don't-care bit. When every unmasked field equals the current time at a tick, the block sets a sticky interrupt flag. If the alarm interrupt enable is set, an active-low interrupt output is driven low while the flag is up. Software clears the flag by reading the status register.

Software reaches the alarm fields, the status register and the control register through a simple single-cycle byte bus. There is a write strobe, a read strobe, a 4-bit address and read data that follows the address combinationally. The time counters are outside this block; their BCD values arrive as inputs and are taken to be already updated in the tick cycle. With every field masked, the block raises the flag on every tick and so serves as a once-per-second update interrupt.

Top module: `alarm_cmp_top`

## Requirements
- R1: After reset, all four alarm bytes, the status byte (address 0xE) and the control byte (address 0xF) read 0x00, and irq_no is 1.
- R2: Alarm bytes are written and read at address 0x8 (seconds), 0x9 (minutes), 0xA (hours) and 0xB (date). Bit 7 is the mask bit. The field occupies bits 6:0 for seconds and minutes and bits 5:0 for hours and date. Any other bit reads back 0.
- R3: The control byte at address 0xF keeps only bit 3, the alarm interrupt enable; its other bits read 0.
- R4: When tick_i is high and every unmasked field equals its time input, status bit 0 (the flag) reads 1 from the next cycle on.
- R5: A field whose mask bit is 1 is left out of the comparison, so a difference in that field does not block a match. A difference in an unmasked field prevents the flag from being set.
- R6: With all four mask bits set, every tick sets the flag, whatever the time inputs hold.
- R7: Without tick_i, time inputs that equal the alarm fields do not set the flag.
- R8: A read of address 0xE returns the flag in bit 0 (other bits 0) and clears the flag from the next cycle, unless R9 applies.
- R9: If a match at a tick falls in the same cycle as a clearing read of 0xE, the read returns the old flag and the flag stays 1.
- R10: irq_no is 0 exactly while the flag and the enable are both 1, and 1 otherwise.
- R11: Writes to address 0xE have no effect on the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (clears the flag on a read of 0xE) |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| tick_i | input | 1 | One-second tick, high for one cycle |
| sec_i | input | 7 | Current seconds, BCD |
| min_i | input | 7 | Current minutes, BCD |
| hour_i | input | 6 | Current hours, BCD |
| date_i | input | 6 | Current date, BCD |
| irq_no | output | 1 | Alarm interrupt, active low |

## Verification
A corrupted alarm byte or mask bit shows up at once as a wrong readback at 0x8 to 0xB. On the next tick it also shows up as a flag that rises or fails to rise, which is visible one cycle later in the status byte and on irq_no. A flag stuck high or low appears on the first status read after a tick, and the following read shows whether it cleared. A wrong enable bit inverts irq_no in the cycle after the control write. The bench probes the cycle where a tick and a clearing read coincide, because the priority between set and clear can only be seen there.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;
  parameter int ADDR_W     = 4;
  parameter int DATA_W     = 8;
  parameter int NUM_FIELDS = 4;
  localparam int MASK_BIT  = DATA_W - 1;
  localparam int IE_BIT    = 3;

  localparam logic [ADDR_W-1:0] ADDR_ALARM0 = 4'h8;
  localparam logic [ADDR_W-1:0] ADDR_STAT   = 4'hE;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 4'hF;

  // seconds/minutes carry 7 BCD bits, hours/date carry 6
  function automatic int field_w(int idx);
    return (idx < 2) ? 7 : 6;
  endfunction

  function automatic logic [DATA_W-1:0] field_mask(int idx);
    return DATA_W'((1 << field_w(idx)) - 1);
  endfunction

  typedef logic [NUM_FIELDS-1:0][DATA_W-1:0] field_vec_t;
endpackage

// File: rtl/alarm_cmp_regs.sv
module alarm_cmp_regs
  import alarm_cmp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output field_vec_t        alarm_o,
  output logic              ie_o
);
  field_vec_t alarm_q;
  logic       ie_q;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    localparam logic [DATA_W-1:0] KEEP = field_mask(i) | (DATA_W'(1) << MASK_BIT);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) alarm_q[i] <= '0;
      else if (wr_en_i && addr_i == ADDR_W'(ADDR_ALARM0 + i)) alarm_q[i] <= wdata_i & KEEP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ie_q <= 1'b0;
    else if (wr_en_i && addr_i == ADDR_CTRL) ie_q <= wdata_i[IE_BIT];
  end

  assign alarm_o = alarm_q;
  assign ie_o    = ie_q;
endmodule

// File: rtl/alarm_cmp_match.sv
module alarm_cmp_match
  import alarm_cmp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  field_vec_t alarm_i,
  input  field_vec_t time_i,
  output logic       match_o
);
  logic [NUM_FIELDS-1:0] hit;
  logic [NUM_FIELDS-1:0] masked;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cmp
    localparam logic [DATA_W-1:0] FM = field_mask(i);
    assign masked[i] = alarm_i[i][MASK_BIT];
    assign hit[i]    = masked[i] | ((alarm_i[i] & FM) == (time_i[i] & FM));
  end

  assign match_o = &hit;

  assert_all_masked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&masked) |-> match_o);
endmodule

// File: rtl/alarm_cmp_flag.sv
module alarm_cmp_flag
  import alarm_cmp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              match_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              flag_o
);
  logic flag_q, set, clr;

  assign set = tick_i & match_i;
  assign clr = rd_en_i & (addr_i == ADDR_STAT);

  // set wins over a coincident clearing read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  flag_q <= 1'b0;
    else if (set) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  assert_flag_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && match_i) |=> flag_q);
  assert_read_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == ADDR_STAT && !(tick_i && match_i)) |=> !flag_q);
  assert_no_tick_no_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !flag_q) |=> !flag_q);
endmodule

// File: rtl/alarm_cmp_top.sv
module alarm_cmp_top
  import alarm_cmp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tick_i,
  input  logic [6:0]        sec_i,
  input  logic [6:0]        min_i,
  input  logic [5:0]        hour_i,
  input  logic [5:0]        date_i,
  output logic              irq_no
);
  field_vec_t alarm;
  field_vec_t time_vec;
  logic       ie, match, flag;

  assign time_vec[0] = DATA_W'(sec_i);
  assign time_vec[1] = DATA_W'(min_i);
  assign time_vec[2] = DATA_W'(hour_i);
  assign time_vec[3] = DATA_W'(date_i);

  alarm_cmp_regs i_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .alarm_o(alarm), .ie_o(ie)
  );

  alarm_cmp_match i_match (
    .clk_i, .rst_ni, .alarm_i(alarm), .time_i(time_vec), .match_o(match)
  );

  alarm_cmp_flag i_flag (
    .clk_i, .rst_ni, .tick_i, .match_i(match), .rd_en_i, .addr_i, .flag_o(flag)
  );

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_FIELDS; i++)
      if (addr_i == ADDR_W'(ADDR_ALARM0 + i)) rdata_o = alarm[i];
    if (addr_i == ADDR_STAT) rdata_o = DATA_W'(flag);
    if (addr_i == ADDR_CTRL) rdata_o = DATA_W'(ie) << IE_BIT;
  end

  assign irq_no = ~(flag & ie);

  assert_irq_needs_enable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> ie);
  assert_stat_write_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_STAT && !tick_i && !flag) |=> !flag);
endmodule

// File: tb/test_alarm_cmp_top.sv
module test_alarm_cmp_top;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_en = 0, rd_en = 0, tick = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic [6:0] sec = 0, mins = 0;
  logic [5:0] hour = 0, date = 0;
  logic irq_no;
  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  alarm_cmp_top i_alarm_cmp_top (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick), .sec_i(sec), .min_i(mins),
    .hour_i(hour), .date_i(date), .irq_no
  );

  // monitor: compare each read against the scoreboard
  always @(negedge clk) if (rst_ni && rd_en) begin
    logic [7:0] e;
    string t;
    n_chk++;
    if (exp_q.size() == 0) begin
      n_fail++; $display("FAIL unexpected read: actual %h expected none", rdata);
    end else begin
      e = exp_q.pop_front(); t = tag_q.pop_front();
      if (rdata !== e) begin
        n_fail++; $display("FAIL %s addr %h: actual %h expected %h", t, addr, rdata, e);
      end
    end
  end

  task automatic op(input logic w, input logic r, input logic [3:0] a,
                    input logic [7:0] d, input logic t);
    wr_en = w; rd_en = r; addr = a; wdata = d; tick = t;
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0; tick = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    op(1, 0, a, d, 0);
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    op(0, 1, a, 8'h00, 0);
  endtask

  task automatic set_time(input logic [6:0] s, input logic [6:0] m,
                          input logic [5:0] h, input logic [5:0] dt);
    sec = s; mins = m; hour = h; date = dt;
  endtask

  task automatic do_tick();
    op(0, 0, 4'h0, 8'h00, 1);
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    n_chk++;
    if (irq_no !== e) begin
      n_fail++; $display("FAIL %s irq_no: actual %b expected %b", t, irq_no, e);
    end
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    for (int i = 8; i < 12; i++) rd(4'(i), 8'h00, "R1");
    rd(4'hE, 8'h00, "R1");
    rd(4'hF, 8'h00, "R1");
    chk_irq(1'b1, "R1");

    // R2 readback and field widths
    wr(4'h8, 8'hFF); rd(4'h8, 8'hFF, "R2");
    wr(4'hA, 8'hFF); rd(4'hA, 8'hBF, "R2");
    wr(4'hB, 8'hC0); rd(4'hB, 8'h80, "R2");
    wr(4'h8, 8'h30); wr(4'h9, 8'h45); wr(4'hA, 8'h12); wr(4'hB, 8'h25);
    rd(4'h8, 8'h30, "R2"); rd(4'h9, 8'h45, "R2");
    rd(4'hA, 8'h12, "R2"); rd(4'hB, 8'h25, "R2");

    // R3 control byte
    wr(4'hF, 8'hFF); rd(4'hF, 8'h08, "R3");
    wr(4'hF, 8'h00); rd(4'hF, 8'h00, "R3");

    // R4 full match, R8 clear on read
    set_time(7'h30, 7'h45, 6'h12, 6'h25); do_tick();
    rd(4'hE, 8'h01, "R4");
    rd(4'hE, 8'h00, "R8");

    // R5 unmasked mismatch blocks, masked mismatch passes
    set_time(7'h31, 7'h45, 6'h12, 6'h25); do_tick();
    rd(4'hE, 8'h00, "R5");
    set_time(7'h30, 7'h45, 6'h13, 6'h25); do_tick();
    rd(4'hE, 8'h00, "R5");
    wr(4'h8, 8'hB0);
    set_time(7'h31, 7'h45, 6'h12, 6'h25); do_tick();
    rd(4'hE, 8'h01, "R5");
    rd(4'hE, 8'h00, "R5");

    // R7 match without tick
    wr(4'h8, 8'h30);
    set_time(7'h30, 7'h45, 6'h12, 6'h25);
    repeat (3) op(0, 0, 4'h0, 8'h00, 0);
    rd(4'hE, 8'h00, "R7");

    // R6 all masked fires on every tick
    for (int i = 8; i < 12; i++) wr(4'(i), 8'h80);
    set_time(7'h07, 7'h59, 6'h23, 6'h01); do_tick(); rd(4'hE, 8'h01, "R6");
    set_time(7'h08, 7'h00, 6'h00, 6'h31); do_tick(); rd(4'hE, 8'h01, "R6");
    set_time(7'h00, 7'h11, 6'h09, 6'h15); do_tick(); rd(4'hE, 8'h01, "R6");
    rd(4'hE, 8'h00, "R6");

    // R9 match coincident with clearing read
    do_tick();
    exp_q.push_back(8'h01); tag_q.push_back("R9");
    op(0, 1, 4'hE, 8'h00, 1);
    rd(4'hE, 8'h01, "R9");
    rd(4'hE, 8'h00, "R9");

    // R11 writes to status ignored
    wr(4'hE, 8'hFF); rd(4'hE, 8'h00, "R11");
    do_tick(); wr(4'hE, 8'h00); rd(4'hE, 8'h01, "R11");

    // R10 interrupt output
    do_tick(); chk_irq(1'b1, "R10");
    wr(4'hF, 8'h08); chk_irq(1'b0, "R10");
    wr(4'hF, 8'h00); chk_irq(1'b1, "R10");
    wr(4'hF, 8'h08); chk_irq(1'b0, "R10");
    rd(4'hE, 8'h01, "R10"); chk_irq(1'b1, "R10");
    wr(4'h8, 8'h05);
    set_time(7'h06, 7'h00, 6'h00, 6'h00); do_tick(); chk_irq(1'b1, "R10");
    rd(4'hE, 8'h00, "R10");

    op(0, 0, 4'h0, 8'h00, 0);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule